// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block puts a small on-chip RAM behind the kind of synchronous front end that a pipelined burst cache SRAM offers. All control inputs except output enable and sleep are sampled on the rising clock edge. Two active-low strobes can start an access. The processor-side strobe always opens a read. The controller-side strobe opens a read or a write, depending on the write enables it sees on the same edge. Three chip selects qualify both strobes. Once an access has started, a 2-bit counter walks the four words of the aligned group. The counter follows either linear or interleaved order. The advance input steps the counter or holds it.

Writes go into the array by byte lane. Each lane is 8 data bits plus 1 parity bit. Read data passes through two register stages before it reaches the output. The output has no back-pressure. `dout_en` marks the cycles in which `dout` carries valid read data, and `dout` reads zero whenever `dout_en` is low. This stands in for a pad in high impedance. A sleep input freezes the block. After sleep drops, a short lockout applies, and any strobe seen during the lockout is reported on `wake_err`.

Top module: `pbsram_core`

## Requirements
- R1: While reset is low and after it is released, `dout_en` is 0, `dout` is 0 and `wake_err` is 0, until a read has passed through the pipeline.
- R2: When `strb_cpu_n` is low on an edge with the chips selected (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), a read starts at `addr`. On that edge `strb_ctl_n`, `adv_n`, `gwr_n`, `bwr_n` and `lane_we_n` have no effect.
- R3: When `strb_ctl_n` is low and the processor strobe is high or blocked, with the chips selected, an access starts at `addr`. It is a write when the write decode of that same edge selects any lane, and a read otherwise.
- R4: When `sel_a_n` is high, `strb_cpu_n` is blocked. A strobe that is seen while the chips are not all selected starts nothing and ends any burst in progress.
- R5: A read performed on edge k shows its data on `dout` after edge k+1.
- R6: Write decode works as follows. If `gwr_n`=0, all lanes are written. Otherwise, if `bwr_n`=0, each lane i whose `lane_we_n[i]` is 0 is written. If both are high, the access is a read. Lane i covers bits [9i+8:9i], and bit 9i+8 is its parity bit.
- R7: On each edge after the start with no strobe seen, `adv_n`=0 steps the counter and `adv_n`=1 holds the current address. The low two address bits are start XOR step when `order_ilv`=1, and start+step mod 4 when `order_ilv`=0. The upper bits stay fixed.
- R8: `dout_en` is 0 whenever `oe_n` is 1, and the effect follows `oe_n` without waiting for a clock.
- R9: After an edge on which the write decode selects any lane (other than a processor-strobe start edge), `dout_en` is 0 until the next edge.
- R10: While `sleep` is 1, `dout_en` is 0 and no access takes place. The array keeps its contents through sleep.
- R11: On the first two edges after `sleep` falls, no strobe starts an access. A strobe on either of those edges sets `wake_err` for the following cycle.
- R12: A read of an address written on an earlier edge returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | External word address |
| strb_cpu_n | input | 1 | Processor-side start strobe, active low |
| strb_ctl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Whole-word write, active low |
| bwr_n | input | 1 | Lane-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Power-down request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not enabled |
| dout_en | output | 1 | Read data valid and driven |
| wake_err | output | 1 | Strobe seen during the wake lockout |

## Verification
The bench builds the block with ADDR_W=6, LANES=2, LANE_W=9 and WAKE_CYC=2. With 64 words, every start offset of a four-word group can be burst-read in both orders, each from its own group, and the data is unique per address. Two lanes are enough to show that a lane write leaves the other lane untouched. A two-edge wake lockout allows each locked edge, and the first free edge, to be observed one by one.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/pbsram_burst.sv
module pbsram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cont,
  input  logic              step,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr
);
  import pbsram_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nxt;

  always_comb begin
    cnt_nxt = step ? cnt_q + 2'd1 : cnt_q;
    if (load) acc_addr = ext_addr;
    else      acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, order_ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
    end else if (cont) begin
      cnt_q  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/pbsram_wrdec.sv
module pbsram_wrdec #(
  parameter int LANES = 2
) (
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] wr_mask
);
  always_comb begin
    if (!gwr_n)      wr_mask = '1;
    else if (!bwr_n) wr_mask = ~lane_we_n;
    else             wr_mask = '0;
  end
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    re,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    rd_q      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/pbsram_outpipe.sv
module pbsram_outpipe #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] s1_data,
  output logic [DATA_W-1:0] q,
  output logic              q_vld
);
  logic v1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      q_vld <= 1'b0;
      q     <= '0;
    end else begin
      v1_q  <= rd_en;
      q_vld <= v1_q;
      if (v1_q) q <= s1_data;
    end
  end

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    order_ilv,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    wake_err
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int WK_W   = $clog2(WAKE_CYC + 1);

  logic              chips_on, cpu_req, ctl_req, run;
  logic              cpu_start, ctl_start, desel, cont;
  logic              wr_any, rd_acc, wr_acc, step;
  logic              active_q, wr_seen_q, wake_err_q;
  logic [WK_W-1:0]   wake_q;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] s1_data, q;
  logic              q_vld;

  // Start and continuation rules
  assign chips_on  = !sel_a_n && sel_b && !sel_c_n;
  assign cpu_req   = !strb_cpu_n && !sel_a_n;
  assign ctl_req   = !strb_ctl_n && !cpu_req;
  assign run       = rst_n && !sleep && (wake_q == '0);
  assign cpu_start = run && cpu_req && chips_on;
  assign ctl_start = run && ctl_req && chips_on;
  assign desel     = run && (cpu_req || ctl_req) && !chips_on;
  assign cont      = run && active_q && !(cpu_req || ctl_req);

  assign wr_any = |wr_mask;
  assign rd_acc = cpu_start || ((ctl_start || cont) && !wr_any);
  assign wr_acc = (ctl_start || cont) && wr_any;
  assign step   = cont && !adv_n;

  pbsram_wrdec #(.LANES(LANES)) u_wrdec (
    .gwr_n     (gwr_n),
    .bwr_n     (bwr_n),
    .lane_we_n (lane_we_n),
    .wr_mask   (wr_mask)
  );

  pbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cpu_start || ctl_start),
    .cont      (cont),
    .step      (step),
    .order_ilv (order_ilv),
    .ext_addr  (addr),
    .acc_addr  (acc_addr)
  );

  pbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .re    (rd_acc),
    .we    (wr_acc ? wr_mask : '0),
    .addr  (acc_addr),
    .wdata (din),
    .rdata (s1_data)
  );

  pbsram_outpipe #(.DATA_W(DATA_W)) u_outpipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_acc),
    .s1_data (s1_data),
    .q       (q),
    .q_vld   (q_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      wr_seen_q  <= 1'b0;
      wake_q     <= '0;
      wake_err_q <= 1'b0;
    end else begin
      if (cpu_start || ctl_start) active_q <= 1'b1;
      else if (desel)             active_q <= 1'b0;
      wr_seen_q <= wr_any && !cpu_start;
      if (sleep)              wake_q <= WK_W'(WAKE_CYC);
      else if (wake_q != '0)  wake_q <= wake_q - 1'b1;
      wake_err_q <= !sleep && (wake_q != '0) && (!strb_cpu_n || !strb_ctl_n);
    end
  end

  assign dout_en  = q_vld && !oe_n && !sleep && !wr_seen_q;
  assign dout     = dout_en ? q : '0;
  assign wake_err = wake_err_q;

  // R5: read data reaches the output two edges after the access
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_acc, 2) |-> q_vld);

  // R9: a write decode blanks the output for the next cycle
  a_r9_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !cpu_start) |=> !dout_en);

  // R10: sleep keeps the output off
  a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  // R11: first and second edges after wake start nothing
  a_r11_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> !(cpu_start || ctl_start));

  a_r11_lock_second: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |=> !(cpu_start || ctl_start));

  // R11: the error flag always has a strobe behind it
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |-> $past(!strb_cpu_n || !strb_ctl_n));

endmodule

// File: tb/tb_pbsram_core.sv
`timescale 1ns/1ps
module tb_pbsram_core;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic strb_cpu_n, strb_ctl_n, adv_n, sel_a_n, sel_b, sel_c_n;
  logic gwr_n, bwr_n, oe_n, order_ilv, sleep;
  logic [NL-1:0] lane_we_n;
  logic [DW-1:0] din, dout;
  logic dout_en, wake_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pbsram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .WAKE_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .order_ilv(order_ilv), .sleep(sleep), .din(din),
    .dout(dout), .dout_en(dout_en), .wake_err(wake_err)
  );

  // {order_ilv, start[1:0], four beats of low address bits}
  localparam logic [10:0] VEC [8] = '{
    11'b1_00_00011011, 11'b1_01_01001110, 11'b1_10_10110001, 11'b1_11_11100100,
    11'b0_00_00011011, 11'b0_01_01101100, 11'b0_10_10110001, 11'b0_11_11000110
  };

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 2731 + 'h155);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    addr = '0; strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_we_n = '1;
    oe_n = 1'b0; order_ilv = 1'b0; sleep = 1'b0; din = '0;
  endtask

  task automatic desel();
    strb_ctl_n = 1'b0; sel_a_n = 1'b1;
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic g_n, input logic b_n, input logic [NL-1:0] lw);
    @(negedge clk); idle(); strb_ctl_n = 1'b0; addr = a; din = d;
    gwr_n = g_n; bwr_n = b_n; lane_we_n = lw;
    @(negedge clk); idle(); desel();
    @(negedge clk); idle();
  endtask

  task automatic rd_word(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic en);
    @(negedge clk); idle(); strb_cpu_n = 1'b0; addr = a;
    @(negedge clk); idle(); desel();
    @(negedge clk); d = dout; en = dout_en; idle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic en;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dout_en in reset", 32'(dout_en), 0);
    chk("R1 dout in reset", 32'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout_en after reset", 32'(dout_en), 0);
    chk("R1 wake_err after reset", 32'(wake_err), 0);

    // preload with whole-word writes (R3, R6)
    for (int a = 0; a < 64; a++) wr_word(AW'(a), pat(a), 1'b0, 1'b1, 2'b11);

    // R7 / R5: burst order table, both orders, every start
    for (int i = 0; i < 8; i++) begin
      logic ilv;
      logic [1:0] st;
      logic [7:0] sq;
      ilv = VEC[i][10]; st = VEC[i][9:8]; sq = VEC[i][7:0];
      @(negedge clk); idle(); order_ilv = ilv; strb_cpu_n = 1'b0; addr = {4'(i), st};
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (k >= 2)
          chk("R7 burst beat", 32'(dout), 32'(pat(int'({4'(i), sq[7-2*(k-2) -: 2]}))));
        idle(); order_ilv = ilv;
        if (k <= 3) adv_n = 1'b0;
        else if (k == 4) desel();
      end
    end

    // R6: lane write, no-write decode, whole write
    wr_word(AW'(5), '1, 1'b1, 1'b0, 2'b10);
    rd_word(AW'(5), d, en);
    chk("R6 lane0 only", 32'(d), 32'({pat(5)[17:9], 9'h1FF}));
    wr_word(AW'(5), '0, 1'b1, 1'b1, 2'b00);
    rd_word(AW'(5), d, en);
    chk("R6 both high no write", 32'(d), 32'({pat(5)[17:9], 9'h1FF}));
    wr_word(AW'(5), 18'h2AAAA, 1'b0, 1'b1, 2'b11);
    rd_word(AW'(5), d, en);
    chk("R6 global write", 32'(d), 32'h2AAAA);

    // R2: processor strobe ignores write enables and the other strobe
    @(negedge clk); idle(); strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; gwr_n = 1'b0; addr = AW'(9);
    @(negedge clk); idle(); desel();
    @(negedge clk);
    chk("R2 start is read", 32'(dout), 32'(pat(9)));
    idle();
    rd_word(AW'(9), d, en);
    chk("R2 array untouched", 32'(d), 32'(pat(9)));

    // R4: blocked processor strobe, then deselect ends a burst
    @(negedge clk); idle(); strb_cpu_n = 1'b0; sel_a_n = 1'b1; addr = AW'(3);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R4 blocked strobe no read", 32'(dout_en), 0);
    @(negedge clk); idle(); strb_cpu_n = 1'b0; addr = AW'(10);
    @(negedge clk); idle(); strb_cpu_n = 1'b0; sel_b = 1'b0;
    @(negedge clk);
    chk("R5 single read", 32'(dout), 32'(pat(10)));
    idle();
    @(negedge clk);
    @(negedge clk);
    chk("R4 burst ended by deselect", 32'(dout_en), 0);

    // R7: suspend holds the address
    @(negedge clk); idle(); strb_cpu_n = 1'b0; addr = AW'(20);
    @(negedge clk); idle();
    @(negedge clk); chk("R7 suspend beat0", 32'(dout), 32'(pat(20))); idle();
    @(negedge clk); chk("R7 suspend beat1", 32'(dout), 32'(pat(20))); idle(); adv_n = 1'b0;
    @(negedge clk); chk("R7 suspend beat2", 32'(dout), 32'(pat(20))); idle(); desel();
    @(negedge clk); chk("R7 advance after suspend", 32'(dout), 32'(pat(21))); idle();

    // R9 / R12: write inside a burst blanks output, then read returns new data
    @(negedge clk); idle(); strb_ctl_n = 1'b0; addr = AW'(33);
    @(negedge clk); idle(); gwr_n = 1'b0; din = 18'h1234F;
    @(negedge clk);
    chk("R9 write blanks output", 32'(dout_en), 0);
    idle();
    @(negedge clk); idle(); desel();
    @(negedge clk);
    chk("R12 read after write", 32'(dout), 32'h1234F);
    idle();

    // R8: output enable acts without a clock
    @(negedge clk); idle(); strb_cpu_n = 1'b0; addr = AW'(7);
    @(negedge clk); idle(); desel();
    @(negedge clk); idle(); oe_n = 1'b1;
    #0.5;
    chk("R8 oe high disables", 32'(dout_en), 0);
    chk("R8 dout zero when off", 32'(dout), 0);
    oe_n = 1'b0;
    #0.5;
    chk("R8 oe low shows data", 32'(dout), 32'(pat(7)));

    // R10 / R11: sleep, lockout and wake error
    @(negedge clk); idle(); strb_cpu_n = 1'b0; addr = AW'(40);
    @(negedge clk); idle(); desel();
    @(negedge clk); idle(); sleep = 1'b1;
    #0.5;
    chk("R10 sleep disables output", 32'(dout_en), 0);
    @(negedge clk); idle(); strb_cpu_n = 1'b0; addr = AW'(40);
    @(negedge clk);
    chk("R11 wake_err first edge", 32'(wake_err), 1);
    @(negedge clk);
    chk("R11 wake_err second edge", 32'(wake_err), 1);
    chk("R11 locked strobe no read", 32'(dout_en), 0);
    @(negedge clk);
    chk("R11 wake_err clear after lockout", 32'(wake_err), 0);
    idle(); desel();
    @(negedge clk);
    chk("R10 contents kept through sleep", 32'(dout), 32'(pat(40)));
    idle();

    @(negedge clk);
    summary();
    $finish;
  end

endmodule